// File: doc/BRIEF.md
# Fixed-Program Register Datapath (3N-2 Evaluator)

This block is a small datapath driven by a hard-wired controller. It has a four-entry register file with two read ports and one write port, and an arithmetic unit that computes add, subtract, multiply, NAND and an equality flag. A six-step control ROM, indexed by a 3-bit step register, drives the operand selects, the operation select and the write-back. The ROM runs one fixed straight-line program that turns an operand N into 3*N-2 and leaves the result in register 3. All arithmetic is 16-bit two's complement and wraps on overflow.

The operand enters through a valid/ready load port. A transfer happens on a rising clock edge when `load_valid` and `load_ready` are both high. `load_ready` is high only while reset is held or while the controller sits in its halt step. A source may hold `load_valid` high for as long as it needs: while the program runs, ready stays low, the request waits, and nothing is consumed. An accepted load presets the registers to R0=1, R1=0, R2=-1 and R3=N. If the load is accepted in halt, it also restarts the program at the first step. `result` always shows register 3. `done` is high while the controller is halted. `eq_flag` shows whether the two operands being read are equal.

Top module: `rom_seq_calc`

## Requirements
- R1: While `rst` is high, `done` is 0 and `load_ready` is 1.
- R2: A load transfers when `load_valid` and `load_ready` are both high at a rising edge. After that edge, `result` equals the `load_n` that was presented.
- R3: After a transfer (or after reset is released with a load taken during reset), the controller advances one step per clock. `done` goes high exactly 5 clocks after the first step is entered.
- R4: When `done` rises, `result` equals (3*N-2) mod 2^16.
- R5: After the fourth step, `result` equals (3*N) mod 2^16, the low 16 bits of the product.
- R6: While halted with no transfer, `done` stays 1 and `result` does not change, because the write enable is 0.
- R7: `eq_flag` follows the operands of each step: 1, 1, 0, (N==3), ((3N mod 2^16)==0xFFFE), and then 1 while halted.
- R8: While the program runs, `load_ready` is 0. A `load_valid` pulse in that window changes neither the trace nor the final result.
- R9: A transfer accepted in halt restarts the program with the new N and produces its 3N-2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset of the step register |
| load_valid | input | 1 | Operand offered |
| load_ready | output | 1 | Operand can be taken (reset or halt) |
| load_n | input | 16 | Operand N |
| done | output | 1 | Controller halted |
| result | output | 16 | Contents of register 3 |
| eq_flag | output | 1 | Current A operand equals B operand |

## Verification
The bench checks `done`, `eq_flag` and `result` on every clock from the transfer until several cycles into halt. A step register that skips or repeats a state, or a ROM row with a wrong select, therefore shows up within one clock as a wrong equality flag, a `result` change on the wrong cycle, or `done` at the wrong time. Operands are chosen so that each data-dependent equality value is seen both ways: N=3 for the multiply step and N=43690 for the final add. Other operands check wrap-around in the multiply and the add.

// File: rtl/rom_seq_calc_pkg.sv
package rom_seq_calc_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_MUL  = 2'b10,
    OP_NAND = 2'b11
  } alu_op_e;

  localparam int STEP_W = 3;
  localparam int SEL_W  = 2;
  localparam logic [STEP_W-1:0] STEP_FIRST = 3'd0;
  localparam logic [STEP_W-1:0] STEP_HALT  = 3'd5;

  typedef struct packed {
    logic [SEL_W-1:0] src_a;
    logic [SEL_W-1:0] src_b;
    logic [SEL_W-1:0] dst;
    alu_op_e          op;
    logic             wr_en;
  } ctrl_word_t;
endpackage

// File: rtl/seq_ctrl_rom.sv
module seq_ctrl_rom
  import rom_seq_calc_pkg::*;
(
  input  logic [STEP_W-1:0] step,
  output ctrl_word_t        word,
  output logic [STEP_W-1:0] step_next
);
  always_comb begin
    step_next = step + STEP_W'(1);
    unique case (step)
      3'd0:    word = '{src_a: 2'd2, src_b: 2'd2, dst: 2'd2, op: OP_ADD, wr_en: 1'b1};
      3'd1:    word = '{src_a: 2'd0, src_b: 2'd0, dst: 2'd1, op: OP_ADD, wr_en: 1'b1};
      3'd2:    word = '{src_a: 2'd0, src_b: 2'd1, dst: 2'd1, op: OP_ADD, wr_en: 1'b1};
      3'd3:    word = '{src_a: 2'd1, src_b: 2'd3, dst: 2'd3, op: OP_MUL, wr_en: 1'b1};
      3'd4:    word = '{src_a: 2'd3, src_b: 2'd2, dst: 2'd3, op: OP_ADD, wr_en: 1'b1};
      default: begin
        word      = '{src_a: 2'd3, src_b: 2'd3, dst: 2'd0, op: OP_ADD, wr_en: 1'b0};
        step_next = STEP_HALT;
      end
    endcase
  end
endmodule

// File: rtl/seq_regfile.sv
module seq_regfile #(
  parameter int W     = 16,
  parameter int NREG  = 4,
  localparam int SW   = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            preset_en,
  input  logic [NREG*W-1:0] preset_val,
  input  logic            wr_en,
  input  logic [SW-1:0]   wr_sel,
  input  logic [W-1:0]    wr_data,
  input  logic [SW-1:0]   rd_sel_a,
  input  logic [SW-1:0]   rd_sel_b,
  output logic [W-1:0]    rd_a,
  output logic [W-1:0]    rd_b,
  output logic [W-1:0]    last_reg
);
  logic [W-1:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (preset_en)
        regs[i] <= preset_val[i*W +: W];
      else if (wr_en && (wr_sel == SW'(i)))
        regs[i] <= wr_data;
    end
  end

  assign rd_a     = regs[rd_sel_a];
  assign rd_b     = regs[rd_sel_b];
  assign last_reg = regs[NREG-1];
endmodule

// File: rtl/seq_alu.sv
module seq_alu
  import rom_seq_calc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         eq
);
  logic [W-1:0] prod;
  assign prod = a * b;
  assign eq   = (a == b);

  always_comb begin
    unique case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_MUL:  y = prod;
      OP_NAND: y = ~(a & b);
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/rom_seq_calc.sv
module rom_seq_calc
  import rom_seq_calc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_valid,
  output logic         load_ready,
  input  logic [W-1:0] load_n,
  output logic         done,
  output logic [W-1:0] result,
  output logic         eq_flag
);
  localparam int NREG = 4;

  logic [STEP_W-1:0] step_q, step_nxt;
  ctrl_word_t        word;
  logic [W-1:0]      opa, opb, alu_y;
  logic              take;
  logic [NREG*W-1:0] preset;

  assign done       = (step_q == STEP_HALT) && !rst;
  assign load_ready = rst || (step_q == STEP_HALT);
  assign take       = load_valid && load_ready;
  assign preset     = {load_n, {W{1'b1}}, {W{1'b0}}, W'(1)};

  always_ff @(posedge clk) begin
    if (rst || take) step_q <= STEP_FIRST;
    else             step_q <= step_nxt;
  end

  seq_ctrl_rom u_rom (
    .step      (step_q),
    .word      (word),
    .step_next (step_nxt)
  );

  seq_regfile #(.W(W), .NREG(NREG)) u_rf (
    .clk        (clk),
    .preset_en  (take),
    .preset_val (preset),
    .wr_en      (word.wr_en && !rst),
    .wr_sel     (word.dst),
    .wr_data    (alu_y),
    .rd_sel_a   (word.src_a),
    .rd_sel_b   (word.src_b),
    .rd_a       (opa),
    .rd_b       (opb),
    .last_reg   (result)
  );

  seq_alu #(.W(W)) u_alu (
    .a  (opa),
    .b  (opb),
    .op (word.op),
    .y  (alu_y),
    .eq (eq_flag)
  );
endmodule

// File: rtl/rom_seq_calc_chk.sv
module rom_seq_calc_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         load_valid,
  input logic         load_ready,
  input logic [W-1:0] load_n,
  input logic         done,
  input logic [W-1:0] result,
  input logic         eq_flag
);
  logic [2:0]   since_start;
  logic [W-1:0] n_cap;
  logic [W-1:0] final_exp;

  assign final_exp = W'(n_cap * W'(3)) - W'(2);

  always_ff @(posedge clk) begin
    if (rst || (load_valid && load_ready)) since_start <= '0;
    else if (since_start != 3'd7)          since_start <= since_start + 3'd1;
    if (load_valid && load_ready) n_cap <= load_n;
  end

  a_r2_load_sets_result: assert property (@(posedge clk) disable iff (rst)
    (load_valid && load_ready) |=> (result == $past(load_n)));

  a_r3_done_timing: assert property (@(posedge clk) disable iff (rst)
    done == (since_start >= 3'd5));

  a_r4_final_value: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (result == final_exp));

  a_r6_halt_holds: assert property (@(posedge clk) disable iff (rst)
    (done && !load_valid) |=> (done && $stable(result)));

  a_r7_halt_equal: assert property (@(posedge clk) disable iff (rst)
    done |-> eq_flag);

  a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    !done |-> !load_ready);
endmodule

bind rom_seq_calc rom_seq_calc_chk #(.W(W)) u_chk (.*);

// File: tb/sim_rom_seq_calc.sv
module sim_rom_seq_calc;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         load_valid = 1'b0;
  logic         load_ready;
  logic [W-1:0] load_n = '0;
  logic         done;
  logic [W-1:0] result;
  logic         eq_flag;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;
  bit finished = 0;

  logic [W+1:0] q_exp [$];
  string        q_tag [$];

  always #10 clk = ~clk;

  rom_seq_calc #(.W(W)) u0 (.*);

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  task automatic check(string tag, logic [W+1:0] act, logic [W+1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual done/eq/result=%h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per cycle while the scoreboard holds any
  always @(negedge clk) begin
    if (q_exp.size() != 0) begin
      logic [W+1:0] e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      check(t, {done, eq_flag, result}, e);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual cycles=%0d expected <= 20000", cycles);
      finish_up();
    end
  end

  function automatic logic [W+1:0] item(logic d, logic z, logic [W-1:0] r);
    return {d, z, r};
  endfunction

  // driver: transfers N, then pushes the expected trace into the scoreboard
  task automatic run(logic [W-1:0] n, bit in_reset, bit poke, string pfx);
    logic [W-1:0] n3;
    n3 = W'(n * W'(3));
    @(negedge clk);
    if (in_reset) rst = 1'b1;
    load_valid = 1'b1;
    load_n     = n;
    @(posedge clk);
    #1;
    load_valid = 1'b0;
    rst        = 1'b0;
    q_exp.push_back(item(1'b0, 1'b1, n));            q_tag.push_back({pfx, " R2 load / R7 step0"});
    q_exp.push_back(item(1'b0, 1'b1, n));            q_tag.push_back({pfx, " R7 step1"});
    q_exp.push_back(item(1'b0, 1'b0, n));            q_tag.push_back({pfx, " R7 step2"});
    q_exp.push_back(item(1'b0, n == W'(3), n));      q_tag.push_back({pfx, " R7 step3"});
    q_exp.push_back(item(1'b0, n3 == 16'hFFFE, n3)); q_tag.push_back({pfx, " R5 product"});
    q_exp.push_back(item(1'b1, 1'b1, n3 - W'(2)));   q_tag.push_back({pfx, " R3 R4 final"});
    for (int k = 0; k < 3; k++) begin
      q_exp.push_back(item(1'b1, 1'b1, n3 - W'(2))); q_tag.push_back({pfx, " R6 halt"});
    end
    if (poke) begin
      @(negedge clk);
      @(negedge clk);
      load_valid = 1'b1;
      load_n     = ~n;
      #1;
      check({pfx, " R8 ready low while busy"}, {2'b00, W'(load_ready)}, {2'b00, W'(0)});
      @(posedge clk);
      #1;
      load_valid = 1'b0;
    end
    wait (q_exp.size() == 0);
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 done in reset", {2'b00, W'(done)}, {2'b00, W'(0)});
    check("R1 ready in reset", {2'b00, W'(load_ready)}, {2'b00, W'(1)});
    run(16'd5, 1'b1, 1'b0, "first");
    run(16'd3, 1'b0, 1'b0, "R9 restart");
    run(16'd43690, 1'b0, 1'b1, "R9 R8 poke");
    run(16'd0, 1'b1, 1'b0, "zero");
    run(16'h7FFF, 1'b0, 1'b0, "R9 wrap");
    run(16'h8000, 1'b0, 1'b1, "R8 neg");
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 done cleared", {2'b00, W'(done)}, {2'b00, W'(0)});
    check("R1 ready in reset", {2'b00, W'(load_ready)}, {2'b00, W'(1)});
    finish_up();
  end
endmodule